// File: doc/BRIEF.md
# Memory-to-PCI Read Parity Handler

This block sits between a memory controller and a PCI target interface. On the read side it takes one memory word per beat together with its stored byte parity. It checks parity across the entire word, even when only one 32-bit lane is returned to the bus. It then produces the PCI data and the even bus parity for the selected lane.

A beat whose memory parity is bad is still delivered, because target ready has already been given when the word arrives. The parity driven onto the bus for that beat is inverted, so the requesting agent sees the error. A one-clock machine-check pulse is also sent to the CPU. If the agent marked the bad beat as not the last of its burst, the next transfer is refused with a target abort. That abort stays raised until the transaction-done strobe arrives.

On the write side the block computes odd byte parity for the memory array. It also pulses a bus parity error when the incoming PCI data, byte enables and parity bit do not have even parity.

An internal controller has three states:
- ST_CLEAN: beats pass.
- ST_ARMED: a bad beat was seen and the burst continues.
- ST_ABORT: the abort is held.

Its transitions are:
- CLEAN to ARMED on a bad beat with the continuation flag set.
- ARMED to ABORT on the next beat.
- ARMED or ABORT to CLEAN on transaction done, which takes priority over every other transition.

Top module: `pci_rd_parity`

## Requirements
- R1: After reset all outputs are 0: `out_vld`, `out_ad`, `out_par`, `mchk`, `tgt_abort`, `wr_mem_chk` and `wr_perr`. The controller starts in ST_CLEAN.
- R2: A read beat presented in ST_CLEAN appears one clock later.
  - `out_vld` is 1.
  - `out_ad` is the lane `rd_word[rd_lane*32 +: 32]`.
  - When the word is good, `out_par` makes the XOR of `out_ad`, the beat's `rd_cbe` and `out_par` equal 0.
  - When no beat is delivered, `out_vld`, `out_ad`, `out_par` and `mchk` are 0.
- R3: Memory parity is odd per byte: `rd_chk[i]` covers bits `8i+7..8i`. A byte is bad when the XOR of its 8 data bits and its check bit is 0. All 8 bytes are checked whatever lane is read.
- R4: A delivered beat with any bad byte has `out_par` inverted from the even value, and is still delivered with `out_vld`=1.
- R5: `mchk` is 1 for exactly the cycle in which a bad beat is delivered, and 0 otherwise.
- R6: After a bad beat with `rd_more`=1, the next read beat is not delivered (`out_vld`=0), and `tgt_abort` becomes 1 in the same cycle that beat's data would have appeared.
- R7: `tgt_abort` stays 1 through any further beats until `xact_done`. It is 0 from the following cycle, and the next beat is handled normally.
- R8: A bad beat with `rd_more`=0 leads to no abort. The next beat is delivered normally.
- R9: For a write beat, one clock later `wr_mem_chk[i]` is the odd parity bit of byte i of `wr_ad`, and 0 when `wr_vld` is 0.
- R10: For a write beat, one clock later `wr_perr` is 1 exactly when the XOR of `wr_ad`, `wr_cbe` and `wr_par` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld | input | 1 | Read beat present |
| rd_word | input | 64 | Memory word |
| rd_chk | input | 8 | Stored odd byte parity of the word |
| rd_lane | input | 1 | Selects which 32-bit lane goes to the bus |
| rd_cbe | input | 4 | Byte-enable value on the bus for this beat |
| rd_more | input | 1 | Another transfer of the burst follows this beat |
| xact_done | input | 1 | Current transaction has ended |
| out_vld | output | 1 | Bus data beat delivered |
| out_ad | output | 32 | Bus data |
| out_par | output | 1 | Bus parity (inverted on a memory error) |
| mchk | output | 1 | Machine-check pulse to the CPU |
| tgt_abort | output | 1 | Target-abort request |
| wr_vld | input | 1 | Write beat present |
| wr_ad | input | 32 | Write data from the bus |
| wr_cbe | input | 4 | Byte enables of the write beat |
| wr_par | input | 1 | Bus parity of the write beat |
| wr_mem_chk | output | 4 | Odd byte parity for memory |
| wr_perr | output | 1 | Bus parity error pulse |

## Verification
If the controller stuck in ST_ARMED or skipped it, the beat right after a bad beat in a burst would show wrong values one clock later. It would either arrive with `out_vld` set, or `tgt_abort` would stay low. If ST_ABORT failed to clear or to hold, `tgt_abort` would be wrong in the cycle after `xact_done` or during later beats. If the parity checker looked only at the selected lane, a fault planted in the other lane would leave `mchk` low and `out_par` uninverted on the very next cycle.

// File: rtl/pci_rd_parity_pkg.sv
package pci_rd_parity_pkg;
    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_ARMED = 2'd1,
        ST_ABORT = 2'd2
    } abort_st_e;
endpackage

// File: rtl/mem_word_check.sv
module mem_word_check #(
    parameter int BYTES = 8
) (
    input  logic [BYTES*8-1:0] word,
    input  logic [BYTES-1:0]   chk,
    output logic               bad
);
    logic [BYTES-1:0] byte_err;

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        // odd parity: data plus check bit must hold an odd number of ones
        assign byte_err[i] = ~(^{word[8*i +: 8], chk[i]});
    end

    assign bad = |byte_err;
endmodule

// File: rtl/odd_byte_par.sv
module odd_byte_par #(
    parameter int BYTES = 4
) (
    input  logic [BYTES*8-1:0] data,
    output logic [BYTES-1:0]   chk
);
    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        assign chk[i] = ~(^data[8*i +: 8]);
    end
endmodule

// File: rtl/bus_par_calc.sv
module bus_par_calc #(
    parameter int DW  = 32,
    parameter int BEW = 4
) (
    input  logic [DW-1:0]  ad,
    input  logic [BEW-1:0] cbe,
    output logic           par
);
    // even parity over data and byte enables
    assign par = ^{ad, cbe};
endmodule

// File: rtl/abort_fsm.sv
module abort_fsm
    import pci_rd_parity_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_vld,
    input  logic beat_bad,
    input  logic beat_more,
    input  logic xact_done,
    output logic deliver,
    output logic abort_q
);
    abort_st_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAN: if (beat_vld && beat_bad && beat_more) state_nx = ST_ARMED;
            ST_ARMED: if (beat_vld) state_nx = ST_ABORT;
            ST_ABORT: state_nx = ST_ABORT;
            default:  state_nx = ST_CLEAN;
        endcase
        if (xact_done) state_nx = ST_CLEAN;
    end

    always_comb begin
        deliver = beat_vld && (state == ST_CLEAN);
        abort_q = (state == ST_ABORT);
    end
endmodule

// File: rtl/pci_rd_parity.sv
module pci_rd_parity #(
    parameter int MEM_W = 64,
    parameter int PCI_W = 32,
    localparam int BYTES  = MEM_W / 8,
    localparam int LANES  = MEM_W / PCI_W,
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int BE_W   = PCI_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_vld,
    input  logic [MEM_W-1:0]   rd_word,
    input  logic [BYTES-1:0]   rd_chk,
    input  logic [SEL_W-1:0]   rd_lane,
    input  logic [BE_W-1:0]    rd_cbe,
    input  logic               rd_more,
    input  logic               xact_done,
    output logic               out_vld,
    output logic [PCI_W-1:0]   out_ad,
    output logic               out_par,
    output logic               mchk,
    output logic               tgt_abort,
    input  logic               wr_vld,
    input  logic [PCI_W-1:0]   wr_ad,
    input  logic [BE_W-1:0]    wr_cbe,
    input  logic               wr_par,
    output logic [BE_W-1:0]    wr_mem_chk,
    output logic               wr_perr
);
    logic             word_bad;
    logic [PCI_W-1:0] lane_data;
    logic             lane_par;
    logic             deliver;
    logic             abort_q;
    logic [BE_W-1:0]  wr_chk_nx;
    logic             wr_par_exp;

    assign lane_data = rd_word[rd_lane*PCI_W +: PCI_W];

    mem_word_check #(.BYTES(BYTES)) u_chk_rd (
        .word (rd_word),
        .chk  (rd_chk),
        .bad  (word_bad)
    );

    bus_par_calc #(.DW(PCI_W), .BEW(BE_W)) u_par_rd (
        .ad  (lane_data),
        .cbe (rd_cbe),
        .par (lane_par)
    );

    abort_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_vld  (rd_vld),
        .beat_bad  (word_bad),
        .beat_more (rd_more),
        .xact_done (xact_done),
        .deliver   (deliver),
        .abort_q   (abort_q)
    );

    odd_byte_par #(.BYTES(BE_W)) u_gen_wr (
        .data (wr_ad),
        .chk  (wr_chk_nx)
    );

    bus_par_calc #(.DW(PCI_W), .BEW(BE_W)) u_par_wr (
        .ad  (wr_ad),
        .cbe (wr_cbe),
        .par (wr_par_exp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld    <= 1'b0;
            out_ad     <= '0;
            out_par    <= 1'b0;
            mchk       <= 1'b0;
            wr_mem_chk <= '0;
            wr_perr    <= 1'b0;
        end else begin
            out_vld    <= deliver;
            out_ad     <= deliver ? lane_data : '0;
            out_par    <= deliver && (lane_par ^ word_bad);
            mchk       <= deliver && word_bad;
            wr_mem_chk <= wr_vld ? wr_chk_nx : '0;
            wr_perr    <= wr_vld && (wr_par_exp ^ wr_par);
        end
    end

    assign tgt_abort = abort_q;
endmodule

// File: rtl/pci_rd_parity_chk.sv
module pci_rd_parity_chk #(
    parameter int PCI_W = 32,
    parameter int BE_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_vld,
    input logic [BE_W-1:0]  rd_cbe,
    input logic             xact_done,
    input logic             out_vld,
    input logic [PCI_W-1:0] out_ad,
    input logic             out_par,
    input logic             mchk,
    input logic             tgt_abort,
    input logic             wr_vld,
    input logic             wr_perr
);
    AST_MCHK_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mchk |-> out_vld); // R5

    AST_PAR_FLAGS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((^{out_ad, $past(rd_cbe), out_par}) == mchk)); // R4

    AST_ABORT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_abort |-> !out_vld); // R6

    AST_ABORT_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_abort) |-> $past(rd_vld)); // R6

    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_abort && !xact_done) |=> tgt_abort); // R7

    AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        xact_done |=> !tgt_abort); // R7

    AST_PERR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_perr |-> $past(wr_vld)); // R10
endmodule

bind pci_rd_parity pci_rd_parity_chk #(.PCI_W(PCI_W), .BE_W(BE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_vld    (rd_vld),
    .rd_cbe    (rd_cbe),
    .xact_done (xact_done),
    .out_vld   (out_vld),
    .out_ad    (out_ad),
    .out_par   (out_par),
    .mchk      (mchk),
    .tgt_abort (tgt_abort),
    .wr_vld    (wr_vld),
    .wr_perr   (wr_perr)
);

// File: tb/sim_pci_rd_parity.sv
`timescale 1ns/1ps
module sim_pci_rd_parity;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_vld = 1'b0;
    logic [63:0] rd_word = '0;
    logic [7:0]  rd_chk = '0;
    logic [0:0]  rd_lane = '0;
    logic [3:0]  rd_cbe = '0;
    logic        rd_more = 1'b0;
    logic        xact_done = 1'b0;
    logic        out_vld;
    logic [31:0] out_ad;
    logic        out_par;
    logic        mchk;
    logic        tgt_abort;
    logic        wr_vld = 1'b0;
    logic [31:0] wr_ad = '0;
    logic [3:0]  wr_cbe = '0;
    logic        wr_par = 1'b0;
    logic [3:0]  wr_mem_chk;
    logic        wr_perr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int m_st = 0; // 0 clean, 1 armed, 2 abort

    typedef struct packed {
        logic        vld;
        logic [31:0] ad;
        logic        par;
        logic        mc;
        logic        abt;
        logic [3:0]  wchk;
        logic        wperr;
    } exp_t;

    exp_t  eq[$];
    string tq[$];

    always #5 clk = ~clk;

    pci_rd_parity u0 (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] mk_chk(input logic [63:0] w);
        logic [7:0] c;
        for (int i = 0; i < 8; i++) c[i] = ~(^w[8*i +: 8]);
        return c;
    endfunction

    // driver: presents one cycle of inputs and queues the result expected after the next edge
    task automatic cycle(input logic v, input logic [63:0] w, input logic [7:0] c, input logic ln,
                         input logic [3:0] be, input logic more, input logic dn,
                         input logic wv, input logic [31:0] wa, input logic [3:0] wbe, input logic wp,
                         input string tag);
        exp_t e;
        logic bad;
        logic dlv;
        int nst;
        logic [31:0] half;
        rd_vld = v; rd_word = w; rd_chk = c; rd_lane = ln; rd_cbe = be;
        rd_more = more; xact_done = dn;
        wr_vld = wv; wr_ad = wa; wr_cbe = wbe; wr_par = wp;
        bad = 1'b0;
        for (int i = 0; i < 8; i++) if (^{w[8*i +: 8], c[i]} == 1'b0) bad = 1'b1;
        half = ln ? w[63:32] : w[31:0];
        dlv = v && (m_st == 0);
        nst = m_st;
        if (m_st == 0 && v && bad && more) nst = 1;
        else if (m_st == 1 && v) nst = 2;
        if (dn) nst = 0;
        e.vld   = dlv;
        e.ad    = dlv ? half : 32'h0;
        e.par   = dlv ? ((^{half, be}) ^ bad) : 1'b0;
        e.mc    = dlv && bad;
        e.abt   = (nst == 2);
        for (int i = 0; i < 4; i++) e.wchk[i] = wv ? ~(^wa[8*i +: 8]) : 1'b0;
        e.wperr = wv && (^{wa, wbe, wp});
        m_st = nst;
        eq.push_back(e);
        tq.push_back(tag);
        @(negedge clk);
    endtask

    task automatic rd(input logic [63:0] w, input logic [7:0] c, input logic ln, input logic [3:0] be,
                      input logic more, input string tag);
        cycle(1'b1, w, c, ln, be, more, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, tag);
    endtask

    task automatic idle(input logic dn, input string tag);
        cycle(1'b0, 64'h0, 8'h0, 1'b0, 4'h0, 1'b0, dn, 1'b0, 32'h0, 4'h0, 1'b0, tag);
    endtask

    task automatic wr(input logic [31:0] a, input logic [3:0] be, input logic p, input string tag);
        cycle(1'b0, 64'h0, 8'h0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, a, be, p, tag);
    endtask

    // monitor: pops one expectation per edge and compares away from the edge
    always @(posedge clk) begin
        if (eq.size() > 0) begin
            exp_t e;
            string t;
            e = eq.pop_front();
            t = tq.pop_front();
            #1;
            chk(t, "out_vld",    {31'h0, out_vld},   {31'h0, e.vld});
            chk(t, "out_ad",     out_ad,             e.ad);
            chk(t, "out_par",    {31'h0, out_par},   {31'h0, e.par});
            chk(t, "mchk",       {31'h0, mchk},      {31'h0, e.mc});
            chk(t, "tgt_abort",  {31'h0, tgt_abort}, {31'h0, e.abt});
            chk(t, "wr_mem_chk", {28'h0, wr_mem_chk}, {28'h0, e.wchk});
            chk(t, "wr_perr",    {31'h0, wr_perr},   {31'h0, e.wperr});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "out_vld",    {31'h0, out_vld},    32'h0);
        chk("R1", "out_ad",     out_ad,              32'h0);
        chk("R1", "mchk",       {31'h0, mchk},       32'h0);
        chk("R1", "tgt_abort",  {31'h0, tgt_abort},  32'h0);
        chk("R1", "wr_mem_chk", {28'h0, wr_mem_chk}, 32'h0);
        chk("R1", "wr_perr",    {31'h0, wr_perr},    32'h0);

        // R2: clean beats on both lanes with assorted byte enables
        w = 64'h0123_4567_89AB_CDEF;
        rd(w, mk_chk(w), 1'b0, 4'h0, 1'b1, "R2");
        rd(w, mk_chk(w), 1'b1, 4'h5, 1'b1, "R2");
        w = 64'hFFFF_0000_A5A5_0001;
        rd(w, mk_chk(w), 1'b1, 4'hE, 1'b0, "R2");
        idle(1'b1, "R2");

        // R3 R4 R5 R8: fault in upper byte while reading lower lane, no continuation
        w = 64'hDEAD_BEEF_1234_5678;
        rd(w, mk_chk(w) ^ 8'h80, 1'b0, 4'h3, 1'b0, "R3");
        rd(w, mk_chk(w), 1'b0, 4'h3, 1'b0, "R8");
        rd(w, mk_chk(w) ^ 8'h01, 1'b1, 4'h0, 1'b0, "R4");
        rd(w, mk_chk(w) ^ 8'h01, 1'b1, 4'h0, 1'b0, "R5");
        idle(1'b1, "R8");

        // R6 R7: fault mid-burst, next beat aborted, abort held until done
        w = 64'h1111_2222_3333_4444;
        rd(w, mk_chk(w), 1'b0, 4'h0, 1'b1, "R6");
        rd(w, mk_chk(w) ^ 8'h10, 1'b1, 4'h0, 1'b1, "R6");
        rd(w, mk_chk(w), 1'b0, 4'h0, 1'b1, "R6");
        rd(w, mk_chk(w), 1'b1, 4'h0, 1'b1, "R7");
        idle(1'b0, "R7");
        idle(1'b1, "R7");
        rd(w, mk_chk(w), 1'b1, 4'h9, 1'b0, "R7");
        idle(1'b0, "R7");

        // R6: gap cycles between bad beat and following beat
        rd(w, mk_chk(w) ^ 8'h02, 1'b0, 4'h0, 1'b1, "R6");
        idle(1'b0, "R6");
        rd(w, mk_chk(w), 1'b0, 4'h0, 1'b0, "R6");
        idle(1'b1, "R7");

        // R9 R10: write-side parity
        wr(32'h0000_0000, 4'h0, 1'b0, "R9");
        wr(32'h8001_FF7E, 4'h2, 1'b0, "R9");
        wr(32'h8001_FF7E, 4'h2, ^{32'h8001_FF7E, 4'h2}, "R10");
        wr(32'h1234_5678, 4'hF, ~(^{32'h1234_5678, 4'hF}), "R10");
        idle(1'b0, "R9");
        idle(1'b0, "R10");

        while (eq.size() > 0) @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule